// File: doc/BRIEF.md
# Ordered Key Unlock Controller

This block sits next to a test access port and frees a chain of one-bit deadlock cells, each of which is held locked until its own secure reset line pulses. A tester shifts a key into a dedicated key data register over the scan interface. When the data register is updated, the held key is compared with the secret stored for the current stage of the sequence. A match pulses that stage's secure reset and advances the sequence. Any other key, including the key of a later stage offered early, releases nothing and sends the sequence back to its first stage.

Per-stage secrets, key length and the number of locks are parameters. One chosen lock also gates loads of the instruction register: its gate output opens only after that lock has been released. A power-on reset relocks everything. The test-logic-reset state of the port clears any partly shifted key but leaves the unlock sequence where it stands.

Top module: `oku_unlock_ctrl`

## Requirements
- R1: After power-on reset every bit of `lock_o` is 1, every bit of `sreset_o` is 0, `ir_open_o` is 0, `scan_out_o` is 0 and the sequence stands at stage 0.
- R2: While `shift_en_i` is high (and `tlr_i` low), each clock moves the key register by one bit; the first bit shifted in becomes key bit 0 after KEY_W shifts, and `scan_out_o` shows the bit that entered KEY_W shifts earlier.
- R3: An update (`update_en_i` high with `shift_en_i` and `tlr_i` low) whose held key equals the secret of the current stage i drives `sreset_o[i]` high for exactly one clock, in the cycle right after the update edge, with no other pulse bit high.
- R4: `lock_o[i]` falls in the same cycle as the first pulse of `sreset_o[i]` and never rises again until power-on reset.
- R5: An update with a key that matches no secret, or the wrong one, gives no pulse and returns the sequence to stage 0, so the stage-0 secret is then accepted again.
- R6: A key equal to a later stage's secret, applied out of order, gives no pulse and returns the sequence to stage 0.
- R7: Once every stage has been released, further updates produce no pulse, whatever the key.
- R8: `tlr_i` high clears the key register to all zeros for that clock and does not move the sequence; an update in the same clock is ignored.
- R9: `ir_open_o` equals the released state of lock IR_LOCK_IDX (default the last lock): 0 until that lock's pulse, 1 from that cycle on.
- R10: An update raised while `shift_en_i` is high is ignored; only the shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tlr_i | input | 1 | Port is in test-logic-reset state |
| shift_en_i | input | 1 | Shift the key data register |
| update_en_i | input | 1 | Update the key data register |
| scan_in_i | input | 1 | Serial key data in |
| scan_out_o | output | 1 | Serial data out of the key register |
| sreset_o | output | NUM_LOCKS | One-clock secure reset pulse per lock |
| lock_o | output | NUM_LOCKS | 1 while a lock has not been released since power-up |
| ir_open_o | output | 1 | Instruction register loads allowed |

## Verification
Every result of this block is registered once: a shift shows on `scan_out_o`, and an update shows on `sreset_o`, `lock_o` and `ir_open_o`, in the cycle that follows the clock edge that sampled the command, with no further delay. The bench drives inputs on the falling edge, lets a behavioural model take the same rising edge, and compares all outputs against the model on the next falling edge, so each result is checked in exactly the cycle it is due and a pulse that lasts two cycles or arrives late is caught. Directed checks at the same sample points name the order, restart, reset and ignore cases.

// File: rtl/oku_pkg.sv
package oku_pkg;

   // What the sequencer does with one qualified command.
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_CLEAR = 2'd1,
      CMD_SHIFT = 2'd2,
      CMD_CHECK = 2'd3
   } oku_cmd_e;

   // Decode the port controls with fixed priority: reset state, shift, update.
   function automatic oku_cmd_e decode_cmd(input logic tlr, input logic shift_en,
                                           input logic update_en);
      if (tlr)            return CMD_CLEAR;
      else if (shift_en)  return CMD_SHIFT;
      else if (update_en) return CMD_CHECK;
      else                return CMD_IDLE;
   endfunction

endpackage

// File: rtl/oku_key_sr.sv
module oku_key_sr
   import oku_pkg::*;
#(
   parameter int KEY_W     = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  oku_cmd_e         cmd_i,
   input  logic             scan_in_i,
   output logic [KEY_W-1:0] key_o,
   output logic             scan_out_o
);

   logic [KEY_W-1:0] sr_q;
   logic [KEY_W-1:0] sr_shifted;

   generate
      if (LSB_FIRST) begin : g_lsb
         // New bits enter at the top and walk down to bit 0.
         assign sr_shifted = {scan_in_i, sr_q[KEY_W-1:1]};
         assign scan_out_o = sr_q[0];
      end else begin : g_msb
         assign sr_shifted = {sr_q[KEY_W-2:0], scan_in_i};
         assign scan_out_o = sr_q[KEY_W-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else begin
         case (cmd_i)
            CMD_CLEAR: sr_q <= '0;
            CMD_SHIFT: sr_q <= sr_shifted;
            default:   sr_q <= sr_q;
         endcase
      end
   end

   assign key_o = sr_q;

endmodule

// File: rtl/oku_key_match.sv
module oku_key_match #(
   parameter int                           NUM_LOCKS = 3,
   parameter int                           KEY_W     = 8,
   parameter logic [NUM_LOCKS*KEY_W-1:0]   SECRETS   = '0,
   localparam int                          PTR_W     = $clog2(NUM_LOCKS + 1)
) (
   input  logic [KEY_W-1:0] key_i,
   input  logic [PTR_W-1:0] stage_i,
   output logic             stage_valid_o,
   output logic             match_o
);

   logic [KEY_W-1:0] secret_tbl [NUM_LOCKS];
   logic [KEY_W-1:0] secret_sel;

   genvar g;
   generate
      for (g = 0; g < NUM_LOCKS; g++) begin : g_tbl
         assign secret_tbl[g] = SECRETS[g*KEY_W +: KEY_W];
      end
   endgenerate

   always_comb begin
      secret_sel    = '0;
      stage_valid_o = 1'b0;
      for (int i = 0; i < NUM_LOCKS; i++) begin
         if (stage_i == PTR_W'(i)) begin
            secret_sel    = secret_tbl[i];
            stage_valid_o = 1'b1;
         end
      end
   end

   assign match_o = stage_valid_o && (key_i == secret_sel);

endmodule

// File: rtl/oku_seq.sv
module oku_seq
   import oku_pkg::*;
#(
   parameter int  NUM_LOCKS = 3,
   localparam int PTR_W     = $clog2(NUM_LOCKS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  oku_cmd_e             cmd_i,
   input  logic                 stage_valid_i,
   input  logic                 match_i,
   output logic [PTR_W-1:0]     stage_o,
   output logic [NUM_LOCKS-1:0] pulse_o,
   output logic [NUM_LOCKS-1:0] released_o
);

   logic [PTR_W-1:0]     stage_q;
   logic [NUM_LOCKS-1:0] pulse_q;
   logic [NUM_LOCKS-1:0] rel_q;
   logic [NUM_LOCKS-1:0] stage_oh;
   logic                 check_now;

   genvar g;
   generate
      for (g = 0; g < NUM_LOCKS; g++) begin : g_oh
         assign stage_oh[g] = (stage_q == PTR_W'(g));
      end
   endgenerate

   assign check_now = (cmd_i == CMD_CHECK) && stage_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         pulse_q <= '0;
         rel_q   <= '0;
      end else begin
         pulse_q <= '0;
         if (check_now) begin
            if (match_i) begin
               pulse_q <= stage_oh;
               rel_q   <= rel_q | stage_oh;
               stage_q <= stage_q + PTR_W'(1);
            end else begin
               stage_q <= '0;
            end
         end
      end
   end

   assign stage_o    = stage_q;
   assign pulse_o    = pulse_q;
   assign released_o = rel_q;

endmodule

// File: rtl/oku_unlock_ctrl.sv
module oku_unlock_ctrl
   import oku_pkg::*;
#(
   parameter int                         NUM_LOCKS   = 3,
   parameter int                         KEY_W       = 8,
   parameter logic [NUM_LOCKS*KEY_W-1:0] SECRETS     = {8'hC3, 8'h5A, 8'h96},
   parameter int                         IR_LOCK_IDX = NUM_LOCKS - 1,
   parameter bit                         LSB_FIRST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tlr_i,
   input  logic                 shift_en_i,
   input  logic                 update_en_i,
   input  logic                 scan_in_i,
   output logic                 scan_out_o,
   output logic [NUM_LOCKS-1:0] sreset_o,
   output logic [NUM_LOCKS-1:0] lock_o,
   output logic                 ir_open_o
);

   localparam int PTR_W = $clog2(NUM_LOCKS + 1);

   generate
      if (NUM_LOCKS < 1) begin : g_bad_locks
         $error("NUM_LOCKS must be at least 1");
      end
      if (KEY_W < 2) begin : g_bad_key
         $error("KEY_W must be at least 2");
      end
      if (IR_LOCK_IDX < 0 || IR_LOCK_IDX >= NUM_LOCKS) begin : g_bad_ir
         $error("IR_LOCK_IDX must name an existing lock");
      end
   endgenerate

   oku_cmd_e             cmd;
   logic [KEY_W-1:0]     key;
   logic [PTR_W-1:0]     stage;
   logic                 stage_valid;
   logic                 match;
   logic [NUM_LOCKS-1:0] released;

   assign cmd = decode_cmd(tlr_i, shift_en_i, update_en_i);

   oku_key_sr #(
      .KEY_W     (KEY_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_key_sr (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (cmd),
      .scan_in_i  (scan_in_i),
      .key_o      (key),
      .scan_out_o (scan_out_o)
   );

   oku_key_match #(
      .NUM_LOCKS (NUM_LOCKS),
      .KEY_W     (KEY_W),
      .SECRETS   (SECRETS)
   ) u_match (
      .key_i         (key),
      .stage_i       (stage),
      .stage_valid_o (stage_valid),
      .match_o       (match)
   );

   oku_seq #(
      .NUM_LOCKS (NUM_LOCKS)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_i         (cmd),
      .stage_valid_i (stage_valid),
      .match_i       (match),
      .stage_o       (stage),
      .pulse_o       (sreset_o),
      .released_o    (released)
   );

   assign lock_o    = ~released;
   assign ir_open_o = released[IR_LOCK_IDX];

endmodule

// File: rtl/oku_unlock_ctrl_chk.sv
module oku_unlock_ctrl_chk #(
   parameter int NUM_LOCKS   = 3,
   parameter int IR_LOCK_IDX = NUM_LOCKS - 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tlr_i,
   input logic                 shift_en_i,
   input logic                 update_en_i,
   input logic [NUM_LOCKS-1:0] sreset_o,
   input logic [NUM_LOCKS-1:0] lock_o,
   input logic                 ir_open_o
);

   p_pulse_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sreset_o));

   p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sreset_o & $past(sreset_o)) == '0);

   p_pulse_needs_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|sreset_o) |-> ($past(update_en_i) && !$past(shift_en_i) && !$past(tlr_i)));

   p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o & ~$past(lock_o)) == '0);

   p_lock_with_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sreset_o & lock_o) == '0);

   p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((sreset_o >> 1) & lock_o) == '0);

   p_ir_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ir_open_o) |-> sreset_o[IR_LOCK_IDX]);

endmodule

bind oku_unlock_ctrl oku_unlock_ctrl_chk #(
   .NUM_LOCKS   (NUM_LOCKS),
   .IR_LOCK_IDX (IR_LOCK_IDX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tlr_i       (tlr_i),
   .shift_en_i  (shift_en_i),
   .update_en_i (update_en_i),
   .sreset_o    (sreset_o),
   .lock_o      (lock_o),
   .ir_open_o   (ir_open_o)
);

// File: tb/oku_unlock_ctrl_tb.sv
module oku_unlock_ctrl_tb;

   localparam int N = 3;
   localparam int W = 8;
   localparam int IR_IDX = N - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tlr = 1'b0, sh = 1'b0, up = 1'b0, si = 1'b0;
   logic scan_out;
   logic [N-1:0] sreset, lock;
   logic ir_open;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   oku_unlock_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .tlr_i(tlr), .shift_en_i(sh), .update_en_i(up),
      .scan_in_i(si), .scan_out_o(scan_out), .sreset_o(sreset), .lock_o(lock),
      .ir_open_o(ir_open)
   );

   // Stage secrets as the requirements use them.
   function automatic logic [W-1:0] secret(input int s);
      case (s)
         0: return 8'h96;
         1: return 8'h5A;
         default: return 8'hC3;
      endcase
   endfunction

   // Behavioural reference model.
   logic m_q[$];
   int m_stage;
   logic [N-1:0] m_rel, m_pulse;

   task automatic model_reset();
      m_q.delete();
      for (int i = 0; i < W; i++) m_q.push_back(1'b0);
      m_stage = 0; m_rel = '0; m_pulse = '0;
   endtask

   task automatic model_step();
      logic [W-1:0] k;
      m_pulse = '0;
      if (tlr) begin
         for (int i = 0; i < W; i++) m_q[i] = 1'b0;
      end else if (sh) begin
         void'(m_q.pop_front());
         m_q.push_back(si);
      end else if (up && m_stage < N) begin
         for (int i = 0; i < W; i++) k[i] = m_q[i];
         if (k == secret(m_stage)) begin
            m_pulse[m_stage] = 1'b1;
            m_rel[m_stage]   = 1'b1;
            m_stage++;
         end else begin
            m_stage = 0;
         end
      end
   endtask

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      check(scan_out === m_q[0], "R2 scan_out", 32'(scan_out), 32'(m_q[0]));
      check(sreset === m_pulse, "R3 sreset pulse", 32'(sreset), 32'(m_pulse));
      check(lock === ~m_rel, "R4 lock status", 32'(lock), 32'(~m_rel));
      check(ir_open === m_rel[IR_IDX], "R9 ir_open", 32'(ir_open), 32'(m_rel[IR_IDX]));
   endtask

   // One clock with the given controls; compare on the following falling edge.
   task automatic tick(input logic t, input logic s, input logic u, input logic d);
      tlr = t; sh = s; up = u; si = d;
      @(posedge clk);
      if (!rst_n) model_reset(); else model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic load_key(input logic [W-1:0] k);
      for (int i = 0; i < W; i++) tick(1'b0, 1'b1, 1'b0, k[i]);
      tick(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic apply_key(input logic [W-1:0] k);
      load_key(k);
      tick(1'b0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      tick(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();
      // R1: reset state
      check(lock === '1 && sreset === '0 && ir_open === 1'b0 && scan_out === 1'b0,
            "R1 reset state", {lock, sreset, ir_open, scan_out}, {3'b111, 3'b000, 2'b00});

      // R2: key pattern walks out after KEY_W shifts
      load_key(8'hA7);
      for (int i = 0; i < W; i++) begin
         check(scan_out === 1'(8'hA7 >> i), "R2 serial delay", 32'(scan_out), 32'(1'(8'hA7 >> i)));
         tick(1'b0, 1'b1, 1'b0, 1'b0);
      end

      // R3, R4: first stage released by its secret
      apply_key(secret(0));
      check(sreset === 3'b001, "R3 stage0 pulse", 32'(sreset), 32'h1);
      check(lock === 3'b110, "R4 stage0 lock", 32'(lock), 32'h6);
      tick(1'b0, 1'b0, 1'b0, 1'b0);
      check(sreset === 3'b000, "R3 pulse one clock", 32'(sreset), 32'h0);

      // R6: later stage's secret out of order, then restart
      apply_key(secret(2));
      check(sreset === 3'b000, "R6 out of order no pulse", 32'(sreset), 32'h0);
      apply_key(secret(1));
      check(sreset === 3'b000, "R6 sequence restarted", 32'(sreset), 32'h0);
      apply_key(secret(0));
      check(sreset === 3'b001, "R5 stage0 accepted again", 32'(sreset), 32'h1);

      // R5: wrong key restarts
      apply_key(8'h00);
      check(sreset === 3'b000, "R5 wrong key no pulse", 32'(sreset), 32'h0);
      apply_key(secret(0));
      check(sreset === 3'b001, "R5 restart at stage0", 32'(sreset), 32'h1);
      check(lock === 3'b110, "R4 relock not allowed", 32'(lock), 32'h6);

      // R8: reset state clears a partial key but keeps the sequence
      for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b0, 1'b1);
      tick(1'b1, 1'b0, 1'b1, 1'b0);
      check(sreset === 3'b000, "R8 update ignored in reset state", 32'(sreset), 32'h0);
      for (int i = 0; i < W; i++) begin
         check(scan_out === 1'b0, "R8 key cleared", 32'(scan_out), 32'h0);
         tick(1'b0, 1'b1, 1'b0, 1'b0);
      end
      apply_key(secret(1));
      check(sreset === 3'b010, "R8 sequence kept", 32'(sreset), 32'h2);
      check(ir_open === 1'b0, "R9 gate still closed", 32'(ir_open), 32'h0);

      // R10: update raised during shift is ignored
      load_key(secret(2));
      tick(1'b0, 1'b1, 1'b1, secret(2)[0]);
      check(sreset === 3'b000, "R10 update during shift", 32'(sreset), 32'h0);
      apply_key(secret(2));
      check(sreset === 3'b100, "R3 last stage pulse", 32'(sreset), 32'h4);
      check(ir_open === 1'b1 && lock === 3'b000, "R9 gate opens", {ir_open, lock}, 32'h8);

      // R7: all released, nothing more fires
      apply_key(secret(0));
      check(sreset === 3'b000, "R7 no pulse after done", 32'(sreset), 32'h0);
      apply_key(8'h11);
      check(sreset === 3'b000 && lock === 3'b000, "R7 wrong key after done", {sreset, lock}, 32'h0);

      // R1: power-on reset relocks
      do_reset();
      check(lock === '1 && ir_open === 1'b0, "R1 relock on reset", {lock, ir_open}, 32'hE);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule